// File: doc/BRIEF.md
# I2C GPIO Expander Register Core

This block is a target on a two-wire serial bus that runs on an oversampled system clock and controls a small group of bidirectional port pins. The bus lines pass through a synchronizer and a glitch filter. A bit-level state machine then decodes START and STOP conditions, matches a fixed 7-bit target address, acknowledges address and data bytes, and shifts read data out.

Behind the bus engine sits a four-entry register map. A pointer selects the entry, and only the first byte of a write transfer sets the pointer. The four entries are:

- the pin-level (input) register, which is read only;
- the drive-value (output) register;
- the read-inversion (polarity) register;
- the direction register.

The pointer never advances by itself. Every later byte of a transfer, and every later read transfer, uses the same entry until a new pointer byte arrives.

The block drives a per-pin output enable and a per-pin output value, and it samples the pin levels. One synchronous active-low reset input serves as both the power-on reset and the external reset. It returns every register and the bus engine to their defaults.

Top module: `gpx_core`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal 1001001 binary (0x92 for a write, 0x93 for a read). Any other address gets no acknowledge and changes no register.
- R2: The first byte of a write transfer is the pointer byte: 0 selects the pin-level register, 1 the drive-value register, 2 the inversion register and 3 the direction register. A pointer byte above 3 is acknowledged but leaves the pointer unchanged.
- R3: The pointer never auto-increments. Consecutive data bytes in one write go to the same register, and consecutive read bytes return the same register.
- R4: A read of pointer 0 returns the four pin levels, each XORed with its inversion bit, in bits 3:0, and ones in bits 7:4. This holds whatever each pin's direction is. Writes to pointer 0 change nothing.
- R5: The drive-value register resets to all ones and reads back its stored bits in 3:0, with ones in 7:4. port_out is 0 on every pin configured as input.
- R6: The inversion register resets to zero and reads back its stored bits in 3:0, with zeros in 7:4.
- R7: The direction register resets to all ones (every pin an input) and reads back its stored bits in 3:0, with ones in 7:4. port_oe[i] is 1 exactly when direction bit i is 0.
- R8: Holding rst_n low for one clock, even in the middle of a transfer, restores every register default, sets the pointer to 0 and returns the bus engine to idle.
- R9: A STOP at any bit position ends the transfer, and a partial byte is discarded. A repeated START begins a new address phase. The target never changes SDA while SCL is high.
- R10: A pulse on SCL or SDA shorter than FILT_LEN system clocks is rejected. For example, a short low pulse on SDA while the bus is idle does not count as a START.
- R11: A byte written to the drive-value register appears on port_out during the acknowledge clock of that data byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversampling the bus |
| rst_n | input | 1 | Synchronous active-low reset (power-on and external) |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| port_in | input | PORT_W | Sampled pin levels |
| port_oe | output | PORT_W | Per-pin output enable |
| port_out | output | PORT_W | Per-pin drive value |

## Verification
A write to the drive-value register commits on the same system clock that opens the acknowledge bit. That clock is also when the changed pin level starts to flow through the pin synchronizer into the pin-level register, so a register write and a pin sample coincide. The bench loops each enabled pin's drive value back into port_in and then reads pointer 0. Each returned byte is judged against a behavioural model of the pin levels and the inversion mask. port_oe and port_out are compared with that model on every clock while no data byte is in flight.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    typedef enum logic [2:0] {
        BS_IDLE,
        BS_ADDR,
        BS_AACK,
        BS_WR,
        BS_WACK,
        BS_RD,
        BS_RACK,
        BS_HOLD
    } bus_st_e;

    localparam logic [1:0] PTR_PINS = 2'd0;
    localparam logic [1:0] PTR_DRV  = 2'd1;
    localparam logic [1:0] PTR_INV  = 2'd2;
    localparam logic [1:0] PTR_DIR  = 2'd3;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/gpx_line_filter.sv
module gpx_line_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          filt;
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.s1 = line_i;
        s_d.s2 = s_q.s1;
        if (s_q.s2 == s_q.filt) begin
            s_d.cnt = '0;
        end else if (s_q.cnt == CW'(FILT_LEN - 1)) begin
            s_d.filt = s_q.s2;
            s_d.cnt  = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.s1   <= 1'b1;
            s_q.s2   <= 1'b1;
            s_q.filt <= 1'b1;
            s_q.cnt  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign line_o = s_q.filt;

    AST_FILT_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.filt != $past(s_q.filt)) |-> ($past(s_q.cnt) == CW'(FILT_LEN - 1))); // R10

endmodule

// File: rtl/gpx_i2c_target.sv
module gpx_i2c_target
    import gpx_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'h49
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_f,
    input  logic              sda_f,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              sda_oe,
    output logic              cmd_wr,
    output logic              data_wr,
    output logic [BYTE_W-1:0] wr_byte
);
    typedef struct packed {
        bus_st_e           st;
        logic              scl_p;
        logic              sda_p;
        logic [3:0]        cnt;
        logic [BYTE_W-1:0] sh;
        logic              rw;
        logic              first;
        logic              acked;
        logic              oe;
    } tgt_t;

    tgt_t s_d, s_q;

    logic rise, fall, start, stop;

    assign rise  = scl_f & ~s_q.scl_p;
    assign fall  = ~scl_f & s_q.scl_p;
    assign start = scl_f & s_q.scl_p & s_q.sda_p & ~sda_f;
    assign stop  = scl_f & s_q.scl_p & ~s_q.sda_p & sda_f;

    always_comb begin
        s_d       = s_q;
        s_d.scl_p = scl_f;
        s_d.sda_p = sda_f;
        cmd_wr    = 1'b0;
        data_wr   = 1'b0;
        if (start) begin
            s_d.st  = BS_ADDR;
            s_d.cnt = '0;
            s_d.oe  = 1'b0;
        end else if (stop) begin
            s_d.st = BS_IDLE;
            s_d.oe = 1'b0;
        end else begin
            case (s_q.st)
                BS_ADDR: begin
                    if (rise) begin
                        s_d.sh  = {s_q.sh[BYTE_W-2:0], sda_f};
                        s_d.cnt = s_q.cnt + 4'd1;
                    end else if (fall && s_q.cnt == 4'd8) begin
                        if (s_q.sh[7:1] == TARGET_ADDR) begin
                            s_d.st = BS_AACK;
                            s_d.oe = 1'b1;
                            s_d.rw = s_q.sh[0];
                        end else begin
                            s_d.st = BS_HOLD;
                        end
                    end
                end
                BS_AACK: begin
                    if (fall) begin
                        s_d.cnt = '0;
                        if (s_q.rw) begin
                            s_d.st = BS_RD;
                            s_d.sh = rd_byte;
                            s_d.oe = ~rd_byte[BYTE_W-1];
                        end else begin
                            s_d.st    = BS_WR;
                            s_d.oe    = 1'b0;
                            s_d.first = 1'b1;
                        end
                    end
                end
                BS_WR: begin
                    if (rise) begin
                        s_d.sh  = {s_q.sh[BYTE_W-2:0], sda_f};
                        s_d.cnt = s_q.cnt + 4'd1;
                    end else if (fall && s_q.cnt == 4'd8) begin
                        s_d.st  = BS_WACK;
                        s_d.oe  = 1'b1;
                        cmd_wr  = s_q.first;
                        data_wr = ~s_q.first;
                    end
                end
                BS_WACK: begin
                    if (fall) begin
                        s_d.st    = BS_WR;
                        s_d.oe    = 1'b0;
                        s_d.cnt   = '0;
                        s_d.first = 1'b0;
                    end
                end
                BS_RD: begin
                    if (rise) begin
                        s_d.cnt = s_q.cnt + 4'd1;
                    end else if (fall) begin
                        if (s_q.cnt == 4'd8) begin
                            s_d.st = BS_RACK;
                            s_d.oe = 1'b0;
                        end else begin
                            s_d.sh = {s_q.sh[BYTE_W-2:0], 1'b0};
                            s_d.oe = ~s_q.sh[BYTE_W-2];
                        end
                    end
                end
                BS_RACK: begin
                    if (rise) begin
                        s_d.acked = ~sda_f;
                    end else if (fall) begin
                        if (s_q.acked) begin
                            s_d.st  = BS_RD;
                            s_d.sh  = rd_byte;
                            s_d.oe  = ~rd_byte[BYTE_W-1];
                            s_d.cnt = '0;
                        end else begin
                            s_d.st = BS_HOLD;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st    <= BS_IDLE;
            s_q.scl_p <= 1'b1;
            s_q.sda_p <= 1'b1;
            s_q.cnt   <= '0;
            s_q.sh    <= '0;
            s_q.rw    <= 1'b0;
            s_q.first <= 1'b0;
            s_q.acked <= 1'b0;
            s_q.oe    <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sda_oe  = s_q.oe;
    assign wr_byte = s_q.sh;

    AST_SDA_QUIET_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(scl_f) && $past(scl_f, 2)) |-> $stable(sda_oe)); // R9

    AST_ACK_ONLY_OWN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == BS_AACK) |-> (s_q.sh[7:1] == TARGET_ADDR)); // R1

endmodule

// File: rtl/gpx_port_regs.sv
module gpx_port_regs
    import gpx_pkg::*;
#(
    parameter int PORT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic [PORT_W-1:0] port_in,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [PORT_W-1:0] port_oe,
    output logic [PORT_W-1:0] port_out
);
    typedef struct packed {
        logic [1:0]        ptr;
        logic [PORT_W-1:0] drv;
        logic [PORT_W-1:0] inv;
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] pin1;
        logic [PORT_W-1:0] pin2;
    } reg_t;

    reg_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.pin1 = port_in;
        s_d.pin2 = s_q.pin1;
        if (cmd_wr) begin
            if (wr_byte < BYTE_W'(4)) begin
                s_d.ptr = wr_byte[1:0];
            end
        end else if (data_wr) begin
            case (s_q.ptr)
                PTR_DRV: s_d.drv = wr_byte[PORT_W-1:0];
                PTR_INV: s_d.inv = wr_byte[PORT_W-1:0];
                PTR_DIR: s_d.dir = wr_byte[PORT_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (s_q.ptr)
            PTR_PINS: begin
                rd_byte = '1;
                rd_byte[PORT_W-1:0] = s_q.pin2 ^ s_q.inv;
            end
            PTR_DRV: begin
                rd_byte = '1;
                rd_byte[PORT_W-1:0] = s_q.drv;
            end
            PTR_INV: begin
                rd_byte = '0;
                rd_byte[PORT_W-1:0] = s_q.inv;
            end
            default: begin
                rd_byte = '1;
                rd_byte[PORT_W-1:0] = s_q.dir;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.ptr  <= PTR_PINS;
            s_q.drv  <= '1;
            s_q.inv  <= '0;
            s_q.dir  <= '1;
            s_q.pin1 <= '0;
            s_q.pin2 <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign port_oe  = ~s_q.dir;
    assign port_out = s_q.drv & ~s_q.dir;

    AST_BAD_CMD_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && wr_byte > BYTE_W'(3)) |=> $stable(s_q.ptr)); // R2

    AST_PIN_REG_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && s_q.ptr == PTR_PINS) |=> ($stable(s_q.drv) && $stable(s_q.inv) && $stable(s_q.dir))); // R4

    AST_RESET_DEFAULTS: assert property (@(posedge clk)
        (rst_n && $past(!rst_n)) |-> (s_q.drv == '1 && s_q.dir == '1 && s_q.inv == '0 && s_q.ptr == PTR_PINS)); // R8

endmodule

// File: rtl/gpx_core.sv
module gpx_core
    import gpx_pkg::*;
#(
    parameter int         PORT_W      = 4,
    parameter int         FILT_LEN    = 4,
    parameter logic [6:0] TARGET_ADDR = 7'h49
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [PORT_W-1:0] port_in,
    output logic [PORT_W-1:0] port_oe,
    output logic [PORT_W-1:0] port_out
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] line_raw;
    logic [N_LINES-1:0] line_flt;
    logic               cmd_wr, data_wr;
    logic [BYTE_W-1:0]  wr_byte, rd_byte;

    assign line_raw = {sda_i, scl_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_filt
        gpx_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (line_raw[g]),
            .line_o (line_flt[g])
        );
    end

    gpx_i2c_target #(.TARGET_ADDR(TARGET_ADDR)) u_target (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f   (line_flt[0]),
        .sda_f   (line_flt[1]),
        .rd_byte (rd_byte),
        .sda_oe  (sda_oe),
        .cmd_wr  (cmd_wr),
        .data_wr (data_wr),
        .wr_byte (wr_byte)
    );

    gpx_port_regs #(.PORT_W(PORT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cmd_wr),
        .data_wr  (data_wr),
        .wr_byte  (wr_byte),
        .port_in  (port_in),
        .rd_byte  (rd_byte),
        .port_oe  (port_oe),
        .port_out (port_out)
    );

endmodule

// File: tb/gpx_core_tb.sv
module gpx_core_tb;
    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 10;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic       rst_n     = 1'b0;
    logic       scl_m     = 1'b1;
    logic       sda_m_low = 1'b0;
    logic [3:0] ext_in    = 4'hA;
    logic       sda_oe;
    logic [3:0] port_oe, port_out, port_in;
    logic       sda_line;

    assign sda_line = ~(sda_m_low | sda_oe);
    assign port_in  = (port_oe & port_out) | (~port_oe & ext_in);

    gpx_core u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .port_in  (port_in),
        .port_oe  (port_oe),
        .port_out (port_out)
    );

    int n_tests = 0;
    int n_fail  = 0;
    logic cmp_en = 1'b0;
    logic [1:0] m_ptr;
    logic [3:0] m_out, m_pol, m_cfg;
    logic [3:0] ack_pout;

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R7", "port_oe per clock", {4'h0, port_oe}, {4'h0, ~m_cfg});
            chk("R5", "port_out per clock", {4'h0, port_out}, {4'h0, m_out & ~m_cfg});
        end
    end

    function automatic logic [7:0] exp_rd();
        logic [3:0] pins;
        pins = (~m_cfg & m_out) | (m_cfg & ext_in);
        case (m_ptr)
            2'd0:    return {4'hF, pins ^ m_pol};
            2'd1:    return {4'hF, m_out};
            2'd2:    return {4'h0, m_pol};
            default: return {4'hF, m_cfg};
        endcase
    endfunction

    task automatic model_reset();
        m_ptr = 2'd0; m_out = 4'hF; m_pol = 4'h0; m_cfg = 4'hF;
    endtask

    task automatic model_write(input logic [7:0] b, input logic first);
        if (first) begin
            if (b < 8'd4) m_ptr = b[1:0];
        end else begin
            case (m_ptr)
                2'd1: m_out = b[3:0];
                2'd2: m_pol = b[3:0];
                2'd3: m_cfg = b[3:0];
                default: ;
            endcase
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m_low = 1'b0; wclk(QTR);
        scl_m = 1'b1;     wclk(QTR);
        sda_m_low = 1'b1; wclk(QTR);
        scl_m = 1'b0;     wclk(QTR);
    endtask

    task automatic bus_stop();
        scl_m = 1'b0; sda_m_low = 1'b1; wclk(QTR);
        scl_m = 1'b1;     wclk(QTR);
        sda_m_low = 1'b0; wclk(QTR);
    endtask

    task automatic put_bit(input logic b);
        wclk(QTR);
        sda_m_low = ~b; wclk(QTR);
        scl_m = 1'b1;   wclk(2 * QTR);
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        cmp_en = 1'b0;
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        wclk(QTR);
        sda_m_low = 1'b0; wclk(QTR);
        scl_m = 1'b1;     wclk(QTR);
        ack = ~sda_line;
        ack_pout = port_out;
        wclk(QTR);
        scl_m = 1'b0;
    endtask

    task automatic get_byte(output logic [7:0] b, input logic master_ack);
        for (int i = 7; i >= 0; i--) begin
            wclk(QTR);
            sda_m_low = 1'b0; wclk(QTR);
            scl_m = 1'b1;     wclk(QTR);
            b[i] = sda_line;  wclk(QTR);
            scl_m = 1'b0;
        end
        wclk(QTR);
        sda_m_low = master_ack; wclk(QTR);
        scl_m = 1'b1;           wclk(2 * QTR);
        scl_m = 1'b0;
    endtask

    task automatic write_txn(input logic [7:0] cmd, input int nd, input logic [7:0] d0, input logic [7:0] d1);
        logic ack;
        bus_start();
        send_byte(8'h92, ack); chk("R1", "write address ack", {7'd0, ack}, 8'd1);
        send_byte(cmd, ack);   chk("R2", "pointer byte ack", {7'd0, ack}, 8'd1);
        model_write(cmd, 1'b1);
        cmp_en = 1'b1;
        for (int i = 0; i < nd; i++) begin
            send_byte(i == 0 ? d0 : d1, ack);
            chk("R3", "data byte ack", {7'd0, ack}, 8'd1);
            model_write(i == 0 ? d0 : d1, 1'b0);
            if (m_ptr == 2'd1)
                chk("R11", "port_out at ack clock", {4'h0, ack_pout}, {4'h0, m_out & ~m_cfg});
            cmp_en = 1'b1;
        end
        bus_stop();
    endtask

    task automatic read_txn(input string req, input int n);
        logic ack;
        logic [7:0] b;
        bus_start();
        send_byte(8'h93, ack); chk("R1", "read address ack", {7'd0, ack}, 8'd1);
        cmp_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            get_byte(b, i < n - 1);
            chk(req, "read byte", b, exp_rd());
        end
        bus_stop();
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic ack;
        logic [7:0] b;
        model_reset();
        wclk(5);
        rst_n = 1'b1;
        wclk(20);
        cmp_en = 1'b1;
        // R7 R5: reset state at the pins
        chk("R7", "port_oe after reset", {4'h0, port_oe}, 8'h00);
        chk("R5", "port_out after reset", {4'h0, port_out}, 8'h00);
        read_txn("R4", 1);
        write_txn(8'd1, 0, 8'h0, 8'h0); read_txn("R5", 1);
        write_txn(8'd2, 0, 8'h0, 8'h0); read_txn("R6", 1);
        write_txn(8'd3, 0, 8'h0, 8'h0); read_txn("R7", 1);

        // R1: foreign address is not acknowledged and changes nothing
        bus_start();
        send_byte(8'h90, ack); chk("R1", "foreign address nack", {7'd0, ack}, 8'd0);
        put_bit(1'b0); put_bit(1'b0);
        bus_stop();
        cmp_en = 1'b1;
        read_txn("R1", 1);

        // R5: drive value has no effect on input pins
        write_txn(8'd1, 1, 8'h05, 8'h0);
        chk("R5", "port_out with all inputs", {4'h0, port_out}, 8'h00);
        read_txn("R5", 1);
        write_txn(8'd3, 1, 8'h0C, 8'h0);
        chk("R7", "port_oe after direction write", {4'h0, port_oe}, 8'h03);
        chk("R5", "port_out after direction write", {4'h0, port_out}, 8'h01);

        // R4: pin levels regardless of direction
        write_txn(8'd0, 0, 8'h0, 8'h0);
        read_txn("R4", 1);
        ext_in = 4'h5; wclk(10);
        read_txn("R4", 1);

        // R6 R3: inversion and repeated reads
        write_txn(8'd2, 1, 8'h06, 8'h0);
        read_txn("R3", 3);
        write_txn(8'd0, 0, 8'h0, 8'h0);
        read_txn("R6", 2);
        write_txn(8'd1, 2, 8'h03, 8'h0A);
        read_txn("R3", 2);

        // R4: write to pointer 0 ignored
        write_txn(8'd0, 1, 8'h00, 8'h0);
        read_txn("R4", 1);
        write_txn(8'd1, 0, 8'h0, 8'h0); read_txn("R4", 1);
        write_txn(8'd2, 0, 8'h0, 8'h0); read_txn("R4", 1);
        write_txn(8'd3, 0, 8'h0, 8'h0); read_txn("R4", 1);

        // R2: pointer byte above 3 keeps pointer
        write_txn(8'd7, 0, 8'h0, 8'h0);
        read_txn("R2", 1);
        write_txn(8'd9, 1, 8'h0E, 8'h0);
        chk("R2", "data after bad pointer hits direction", {4'h0, port_oe}, 8'h01);
        read_txn("R2", 1);

        // R9: repeated START
        bus_start();
        send_byte(8'h92, ack); chk("R9", "address ack", {7'd0, ack}, 8'd1);
        send_byte(8'd1, ack);  model_write(8'd1, 1'b1); cmp_en = 1'b1;
        bus_start();
        send_byte(8'h93, ack); chk("R9", "address ack after repeated start", {7'd0, ack}, 8'd1);
        cmp_en = 1'b1;
        get_byte(b, 1'b0);     chk("R9", "read after repeated start", b, exp_rd());
        bus_stop();

        // R9: STOP in the middle of a data byte
        bus_start();
        send_byte(8'h92, ack);
        send_byte(8'd3, ack);  model_write(8'd3, 1'b1); cmp_en = 1'b1;
        put_bit(1'b0); put_bit(1'b0); put_bit(1'b0); put_bit(1'b0);
        bus_stop();
        chk("R9", "port_oe after aborted byte", {4'h0, port_oe}, {4'h0, ~m_cfg});
        read_txn("R9", 1);

        // R10: short SDA pulse while idle is not a START
        wclk(QTR);
        sda_m_low = 1'b1; wclk(2);
        sda_m_low = 1'b0; wclk(QTR);
        scl_m = 1'b0; wclk(QTR);
        send_byte(8'h92, ack);
        chk("R10", "no ack after glitch", {7'd0, ack}, 8'd0);
        bus_stop();
        cmp_en = 1'b1;
        read_txn("R10", 1);

        // R8: reset in the middle of a transfer
        bus_start();
        send_byte(8'h92, ack);
        send_byte(8'd1, ack);
        wclk(QTR);
        rst_n = 1'b0; wclk(3);
        model_reset();
        rst_n = 1'b1; wclk(2 * QTR);
        bus_stop();
        cmp_en = 1'b1;
        chk("R8", "port_oe after reset", {4'h0, port_oe}, 8'h00);
        read_txn("R8", 1);
        write_txn(8'd1, 0, 8'h0, 8'h0); read_txn("R8", 1);
        write_txn(8'd2, 0, 8'h0, 8'h0); read_txn("R8", 1);

        wclk(20);
        finish_run();
    end

endmodule